// File: doc/BRIEF.md
# Multi-Mode Iterative Non-Restoring Divider

This block is a sequential divider that resolves one quotient bit per clock with a non-restoring recurrence. It returns a 16-bit quotient and a 16-bit remainder. A start pulse captures the operands, the mode and the divisor. The block then runs through a fixed sequence of 18 steps. The first step prepares the dividend. Sixteen steps each produce one quotient bit. The last step corrects the remainder and applies the result signs.

Five operations share the same loop: signed and unsigned division of a 32-bit dividend by a 16-bit divisor, signed and unsigned division of a 16-bit dividend by a 16-bit divisor, and a signed fractional division of two Q1.15 values. The integer modes use the first step to extend the dividend and to place it in the shift registers. The fractional mode aligns its operand when the start is accepted, so its first step does nothing. Every mode therefore takes the same time.

A step-enable input can hold the sequence between steps for any number of cycles, and the result is not changed by the pause. Results and the divide-by-zero flag are registered when the operation finishes and stay fixed until the next operation finishes.

Top module: `nr_divider`

## Requirements
- R1: `mode_i` selects the operation. The codes are: 0 = 32/16 signed, 1 = 32/16 unsigned, 2 = 16/16 signed, 3 = 16/16 unsigned, 4 = 16/16 signed fractional. Codes 5, 6 and 7 behave exactly like code 1.
- R2: In the 32/16 modes all 32 bits of `dividend_i` are used. The outputs are correct whenever the true quotient fits: 0..65535 for unsigned, -32768..32767 for signed.
- R3: In the 16/16 modes only `dividend_i[15:0]` is used. It is sign-extended in the signed mode and zero-extended in the unsigned mode, and `dividend_i[31:16]` has no effect on any output.
- R4: Signed quotients truncate toward zero. A nonzero remainder takes the sign of the dividend, and quotient times divisor plus remainder equals the dividend.
- R5: In fractional mode, dividend a and divisor b are Q1.15. The quotient is trunc(a·2^15 / b), and the remainder is a·2^15 − quotient·b. Both are two's complement.
- R6: With `step_en_i` held high, `done_o` is high in the 19th cycle, counting the cycle in which `start_i` is sampled as the first. `busy_o` is high in every cycle between those two.
- R7: Each cycle in which `step_en_i` is low while busy delays `done_o` by exactly one cycle and leaves the results unchanged.
- R8: `done_o` is a one-cycle pulse. `busy_o` is low while `done_o` is high. `quot_o`, `rem_o` and `div_zero_o` change only in a cycle where `done_o` is high.
- R9: `start_i` while busy is ignored. It does not change the running operation and does not produce an extra `done_o`.
- R10: A zero divisor raises `div_zero_o` together with `done_o`. Quotient and remainder are then unspecified but stay stable. The next operation with a nonzero divisor clears the flag.
- R11: While `rst_ni` is low, `busy_o`, `done_o`, `quot_o`, `rem_o` and `div_zero_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when not busy |
| mode_i | input | 3 | Operation select, sampled with start |
| dividend_i | input | 32 | Dividend; upper half unused in 16/16 modes |
| divisor_i | input | 16 | Divisor |
| step_en_i | input | 1 | Allows the next step; low pauses the sequence |
| quot_o | output | 16 | Quotient, held until the next completion |
| rem_o | output | 16 | Remainder, held until the next completion |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last completed operation had a zero divisor |

## Verification
Results reach the ports only at completion, so a corrupted partial remainder or quotient bit stays hidden for up to 18 cycles. It then shows as a wrong quotient or remainder in the `done_o` cycle. A step counter that is off by any amount moves `done_o` away from the 19-cycle mark, or away from 19 plus the number of paused cycles. A wrong sign flag stays invisible for same-sign operands and shows only when the operand signs differ or when the dividend is negative. Mixed-sign, zero-remainder and extreme-magnitude cases are therefore essential.

// File: rtl/divnr_pkg.sv
package divnr_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_S32  = 3'd0,
    MD_U32  = 3'd1,
    MD_S16  = 3'd2,
    MD_U16  = 3'd3,
    MD_FRAC = 3'd4
  } div_mode_e;

  function automatic logic mode_signed(div_mode_e m);
    return (m == MD_S32) || (m == MD_S16) || (m == MD_FRAC);
  endfunction
endpackage

// File: rtl/divnr_ctrl.sv
module divnr_ctrl #(
  parameter int W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic step_en_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic init_o,
  output logic iter_o,
  output logic fix_o
);
  localparam int N_STEPS = W + 2;
  localparam int CNT_W   = $clog2(N_STEPS);
  localparam int LAST    = N_STEPS - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic             fire;
  logic             at_first, at_last;

  assign fire     = busy_q & step_en_i;
  assign at_first = (cnt_q == '0);
  assign at_last  = (cnt_q == CNT_W'(LAST));

  assign load_o = start_i & ~busy_q;
  assign init_o = fire & at_first;
  assign fix_o  = fire & at_last;
  assign iter_o = fire & ~at_first & ~at_last;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (fire) begin
        if (at_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  p_stall_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !step_en_i) |=> (busy_o && !done_o));
  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(cnt_q) <= LAST));
endmodule

// File: rtl/divnr_prep.sv
// Extends the dividend for the mode and splits its magnitude into halves.
module divnr_prep
  import divnr_pkg::*;
#(
  parameter int W = 16
) (
  input  div_mode_e      mode_i,
  input  logic [2*W-1:0] dvd_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o,
  output logic           neg_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] ext, mag;

  always_comb begin
    case (mode_i)
      MD_S16, MD_FRAC: ext = {{W{dvd_i[W-1]}}, dvd_i[W-1:0]};
      MD_U16:          ext = {{W{1'b0}}, dvd_i[W-1:0]};
      default:         ext = dvd_i;
    endcase
    neg_o = mode_signed(mode_i) & ext[DW-1];
    mag   = neg_o ? (~ext + 1'b1) : ext;
    // Q1.15 alignment: dividend scaled by 2^(W-1)
    if (mode_i == MD_FRAC) mag = mag << (W - 1);
    hi_o = mag[DW-1:W];
    lo_o = mag[W-1:0];
  end
endmodule

// File: rtl/divnr_step.sv
// One non-restoring step: shift in next dividend bit, add or subtract divisor.
module divnr_step #(
  parameter int W = 16
) (
  input  logic [W+1:0] p_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] dmag_i,
  output logic [W+1:0] p_o,
  output logic [W-1:0] a_o
);
  localparam int PW = W + 2;

  logic [PW-1:0] sh, dx;

  assign sh  = {p_i[PW-2:0], a_i[W-1]};
  assign dx  = {2'b00, dmag_i};
  assign p_o = p_i[PW-1] ? (sh + dx) : (sh - dx);
  assign a_o = {a_i[W-2:0], ~p_o[PW-1]};
endmodule

// File: rtl/divnr_fix.sv
// Final step: restore a negative remainder, then apply the result signs.
module divnr_fix #(
  parameter int W = 16
) (
  input  logic         p_neg_i,
  input  logic [W-1:0] p_lo_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] dmag_i,
  input  logic         neg_q_i,
  input  logic         neg_r_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] r_mag;

  assign r_mag  = p_neg_i ? (p_lo_i + dmag_i) : p_lo_i;
  assign quot_o = neg_q_i ? (~a_i + 1'b1) : a_i;
  assign rem_o  = neg_r_i ? (~r_mag + 1'b1) : r_mag;
endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import divnr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [2*W-1:0]    dividend_i,
  input  logic [W-1:0]      divisor_i,
  input  logic              step_en_i,
  output logic [W-1:0]      quot_o,
  output logic [W-1:0]      rem_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              div_zero_o
);
  localparam int PW = W + 2;
  localparam int DW = 2 * W;

  div_mode_e     mode_in, mode_q;
  logic [DW-1:0] dvd_q;
  logic [W-1:0]  dmag_q;
  logic          d_neg_q, n_neg_q, dz_q;
  logic [PW-1:0] p_q;
  logic [W-1:0]  a_q;
  logic [W-1:0]  quot_q, rem_q;
  logic          dz_out_q;

  logic          ld, st_init, st_iter, st_fix;
  logic [W-1:0]  ld_hi, ld_lo, in_hi, in_lo;
  logic          ld_neg, in_neg, d_neg_in;
  logic [PW-1:0] nx_p;
  logic [W-1:0]  nx_a, fx_q, fx_r;

  assign mode_in  = div_mode_e'(mode_i);
  assign d_neg_in = mode_signed(mode_in) & divisor_i[W-1];

  divnr_ctrl #(.W(W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .step_en_i (step_en_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .load_o    (ld),
    .init_o    (st_init),
    .iter_o    (st_iter),
    .fix_o     (st_fix)
  );

  // Fractional operands are aligned at load; integer ones in the first step.
  divnr_prep #(.W(W)) u_prep_ld (
    .mode_i (mode_in),
    .dvd_i  (dividend_i),
    .hi_o   (ld_hi),
    .lo_o   (ld_lo),
    .neg_o  (ld_neg)
  );

  divnr_prep #(.W(W)) u_prep_init (
    .mode_i (mode_q),
    .dvd_i  (dvd_q),
    .hi_o   (in_hi),
    .lo_o   (in_lo),
    .neg_o  (in_neg)
  );

  divnr_step #(.W(W)) u_step (
    .p_i    (p_q),
    .a_i    (a_q),
    .dmag_i (dmag_q),
    .p_o    (nx_p),
    .a_o    (nx_a)
  );

  divnr_fix #(.W(W)) u_fix (
    .p_neg_i (p_q[PW-1]),
    .p_lo_i  (p_q[W-1:0]),
    .a_i     (a_q),
    .dmag_i  (dmag_q),
    .neg_q_i (n_neg_q ^ d_neg_q),
    .neg_r_i (n_neg_q),
    .quot_o  (fx_q),
    .rem_o   (fx_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MD_S32;
      dvd_q   <= '0;
      dmag_q  <= '0;
      d_neg_q <= 1'b0;
      n_neg_q <= 1'b0;
      dz_q    <= 1'b0;
      p_q     <= '0;
      a_q     <= '0;
    end else if (ld) begin
      mode_q  <= mode_in;
      dvd_q   <= dividend_i;
      d_neg_q <= d_neg_in;
      dmag_q  <= d_neg_in ? (~divisor_i + 1'b1) : divisor_i;
      dz_q    <= (divisor_i == '0);
      if (mode_in == MD_FRAC) begin
        p_q     <= {2'b00, ld_hi};
        a_q     <= ld_lo;
        n_neg_q <= ld_neg;
      end
    end else if (st_init) begin
      if (mode_q != MD_FRAC) begin
        p_q     <= {2'b00, in_hi};
        a_q     <= in_lo;
        n_neg_q <= in_neg;
      end
    end else if (st_iter) begin
      p_q <= nx_p;
      a_q <= nx_a;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q   <= '0;
      rem_q    <= '0;
      dz_out_q <= 1'b0;
    end else if (st_fix) begin
      quot_q   <= fx_q;
      rem_q    <= fx_r;
      dz_out_q <= dz_q;
    end
  end

  assign quot_o     = quot_q;
  assign rem_o      = rem_q;
  assign div_zero_o = dz_out_q;

  p_hold_results_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(div_zero_o)));
  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(dvd_q) && $stable(dmag_q) && $stable(dz_q)));
  p_zero_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (div_zero_o == dz_q));
  p_frac_init_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_init && mode_q == MD_FRAC) |=> ($stable(p_q) && $stable(a_q)));
endmodule

// File: tb/tb_nr_divider.sv
module tb_nr_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [2:0]  mode_i;
  logic [31:0] dividend_i;
  logic [15:0] divisor_i;
  logic        step_en_i;
  logic [15:0] quot_o, rem_o;
  logic        busy_o, done_o, div_zero_o;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] q;
    logic [15:0] r;
    bit          dz;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk_i = ~clk_i;

  nr_divider dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .step_en_i(step_en_i),
    .quot_o(quot_o), .rem_o(rem_o), .busy_o(busy_o), .done_o(done_o),
    .div_zero_o(div_zero_o)
  );

  function automatic void chk(input bit ok, input string req, input string what,
                              input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // Reference from the requirements (R1..R5)
  function automatic void model(input logic [2:0] md, input logic [31:0] dvd,
                                input logic [15:0] dvs, output longint q, output longint r);
    longint n, d;
    case (md)
      3'd0: begin n = longint'($signed(dvd)); d = longint'($signed(dvs)); end
      3'd2: begin n = longint'($signed(dvd[15:0])); d = longint'($signed(dvs)); end
      3'd3: begin n = longint'(dvd[15:0]); d = longint'(dvs); end
      3'd4: begin n = longint'($signed(dvd[15:0])) * 32768; d = longint'($signed(dvs)); end
      default: begin n = longint'(dvd); d = longint'(dvs); end
    endcase
    if (d == 0) begin q = 0; r = 0; end
    else begin q = n / d; r = n % d; end
  endfunction

  function automatic bit fits(input logic [2:0] md, input longint q);
    if (md == 3'd0 || md == 3'd2 || md == 3'd4) return (q >= -32768) && (q <= 32767);
    return (q >= 0) && (q <= 65535);
  endfunction

  function automatic void push_expect(input logic [2:0] md, input logic [31:0] dvd,
                                      input logic [15:0] dvs, input string req);
    exp_t e;
    longint q, r;
    model(md, dvd, dvs, q, r);
    e.q = q[15:0]; e.r = r[15:0]; e.dz = (dvs == 16'h0); e.req = req;
    sb_q.push_back(e);
  endfunction

  // Monitor: pop the oldest expectation at each completion
  always @(negedge clk_i) begin
    exp_t e;
    if (rst_ni === 1'b1 && done_o === 1'b1 && !finished) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        e = sb_q.pop_front();
        chk(div_zero_o == e.dz, (e.dz ? "R10" : e.req), "div_zero", div_zero_o, e.dz);
        if (!e.dz) begin
          chk(quot_o == e.q, e.req, "quotient", quot_o, e.q);
          chk(rem_o == e.r, e.req, "remainder", rem_o, e.r);
        end
      end
    end
  end

  // Driver: called at a negedge, returns at the negedge where done_o is seen
  task automatic run_op(input logic [2:0] md, input logic [31:0] dvd, input logic [15:0] dvs,
                        input string req, input int stall_from, input int stall_len, input bit poke);
    int cyc;
    push_expect(md, dvd, dvs, req);
    mode_i = md; dividend_i = dvd; divisor_i = dvs; start_i = 1'b1; step_en_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    // scramble inputs: operands must have been captured at start
    dividend_i = ~dvd; divisor_i = dvs ^ 16'h5a5b; mode_i = md ^ 3'd1;
    while (done_o !== 1'b1 && cyc < 100) begin
      step_en_i = !(cyc >= stall_from && cyc < stall_from + stall_len);
      start_i   = poke && (cyc == 5);
      if (cyc == 2) chk(busy_o === 1'b1, "R6", "busy while running", busy_o, 1);
      @(negedge clk_i);
      cyc++;
    end
    step_en_i = 1'b1; start_i = 1'b0;
    chk(cyc == 19 + stall_len, (stall_len > 0) ? "R7" : "R6", "latency", cyc, 19 + stall_len);
  endtask

  // R8: done drops after one cycle, results hold while idle
  task automatic hold_check(input int cycles);
    logic [15:0] q0, r0;
    logic        z0;
    q0 = quot_o; r0 = rem_o; z0 = div_zero_o;
    @(negedge clk_i);
    chk(done_o === 1'b0, "R8", "done pulse width", done_o, 0);
    chk(busy_o === 1'b0, "R8", "idle after done", busy_o, 0);
    repeat (cycles) @(negedge clk_i);
    chk(quot_o == q0 && rem_o == r0 && div_zero_o == z0, "R8", "results held",
        {quot_o, rem_o}, {q0, r0});
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; step_en_i = 1'b1;
    mode_i = 3'd0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(busy_o === 1'b0 && done_o === 1'b0, "R11", "busy/done in reset", {busy_o, done_o}, 0);
    chk(quot_o === 16'h0 && rem_o === 16'h0 && div_zero_o === 1'b0, "R11", "results in reset",
        {quot_o, rem_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 unsigned 32/16, including the largest fitting quotient
    run_op(3'd1, 32'h1234_5678, 16'h9abc, "R2", 0, 0, 0);
    run_op(3'd1, 32'hfffe_0001, 16'hffff, "R2", 0, 0, 0);
    run_op(3'd1, 32'h0000_fffe, 16'h0001, "R2", 0, 0, 0);
    // R2/R4 signed 32/16, all sign combinations
    run_op(3'd0, -32'sd1000000, 16'd37, "R4", 0, 0, 0);
    run_op(3'd0, 32'sd1000000, -16'sd37, "R4", 0, 0, 0);
    run_op(3'd0, -32'sd1000000, -16'sd37, "R4", 0, 0, 0);
    run_op(3'd0, -32'sd7, 16'sd2, "R4", 0, 0, 0);
    run_op(3'd0, -32'sd6, 16'sd3, "R4", 0, 0, 0);
    run_op(3'd0, -32'sd1073741824, 16'sd32767, "R2", 0, 0, 0);
    // R3 16/16 with junk in the upper half
    run_op(3'd2, 32'habcd_fff9, 16'h0002, "R3", 0, 0, 0);
    run_op(3'd3, 32'h1234_fff9, 16'h0002, "R3", 0, 0, 0);
    run_op(3'd2, 32'h5555_8000, 16'h0001, "R3", 0, 0, 0);
    run_op(3'd3, 32'hffff_0007, 16'hfff0, "R3", 0, 0, 0);
    // R5 fractional
    run_op(3'd4, 32'h0000_2000, 16'h4000, "R5", 0, 0, 0);
    run_op(3'd4, 32'h0000_e000, 16'h4000, "R5", 0, 0, 0);
    run_op(3'd4, 32'hffff_1000, 16'h3000, "R5", 0, 0, 0);
    run_op(3'd4, 32'h0000_f000, 16'hd000, "R5", 0, 0, 0);
    // R1 codes 5..7 behave as 32/16 unsigned
    run_op(3'd5, 32'h00ab_cdef, 16'h1234, "R1", 0, 0, 0);
    run_op(3'd7, 32'h8000_0001, 16'hc000, "R1", 0, 0, 0);
    run_op(3'd6, 32'h0000_ffff, 16'h0010, "R1", 0, 0, 0);
    // R7 stalls, early and late in the sequence
    run_op(3'd0, -32'sd123456, 16'sd789, "R7", 3, 4, 0);
    run_op(3'd4, 32'h0000_c123, 16'h7abc, "R7", 17, 2, 0);
    run_op(3'd1, 32'h0777_1111, 16'h8001, "R7", 1, 1, 0);
    hold_check(12);
    // R9 start while busy is ignored
    run_op(3'd3, 32'h0000_4321, 16'h0011, "R9", 0, 0, 1);
    hold_check(25);
    // R10 zero divisor, stable results, then flag cleared
    run_op(3'd0, 32'h0001_2345, 16'h0000, "R10", 0, 0, 0);
    hold_check(8);
    run_op(3'd4, 32'h0000_4000, 16'h0000, "R10", 0, 0, 0);
    run_op(3'd2, 32'h0000_0064, 16'h0007, "R10", 0, 0, 0);

    // Mixed operands across modes
    for (int i = 0; i < 150; i++) begin
      logic [2:0]  md;
      logic [31:0] dvd;
      logic [15:0] dvs;
      longint      q, r;
      int          tries;
      md = 3'(i % 5);
      tries = 0;
      do begin
        dvs = 16'($urandom);
        dvd = $urandom >> ($urandom % 32);
        if ($urandom % 2) dvd = -dvd;
        model(md, dvd, dvs, q, r);
        tries++;
      end while ((dvs == 16'h0 || !fits(md, q)) && tries < 200);
      if (dvs != 16'h0 && fits(md, q))
        run_op(md, dvd, dvs, (md == 3'd4) ? "R5" : ((md >= 3'd2) ? "R3" : "R2"),
               2 + i % 13, (i % 4 == 0) ? i % 3 : 0, 0);
    end

    repeat (30) @(negedge clk_i);
    chk(sb_q.size() == 0, "R9", "pending expectations", sb_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_err++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule